// File: doc/BRIEF.md
# Packed Halfword Multiply and Byte Reduction Unit

This block is a purely combinational datapath slice for a 64-bit packed integer pipe. It takes two 64-bit operands and a 3-bit opcode and returns one 64-bit result in the same cycle. There are two groups of operations. The first group works on lanes: four 16-bit halfword multiplies that keep either the low or the high half of the 32-bit product, a pairwise multiply-add that folds adjacent halfword products into 32-bit words, and an unsigned 32x32 multiply of the lowest word. The second group works on bytes: a per-byte unsigned absolute difference, a horizontal sum of bytes, and a sum of absolute differences. The surrounding pipeline supplies the registers.

Operand A is `src_a_i` and operand B is `src_b_i`. Halfword lane k occupies bits [16k+15:16k], and byte lane k occupies bits [8k+7:8k]. Word lane k occupies bits [32k+31:32k].

Top module: `pmul_sad_unit`

## Requirements
- R1: With opcode 0, each halfword lane of the result is the low 16 bits of the product of the matching A and B halfwords.
- R2: With opcode 1, each halfword lane of the result is bits [31:16] of the signed (two's complement) 32-bit product of the matching halfwords.
- R3: With opcode 2, each halfword lane of the result is bits [31:16] of the unsigned 32-bit product of the matching halfwords.
- R4: With opcode 3, result word 0 is A0*B0 + A1*B1 and result word 1 is A2*B2 + A3*B3. The halfwords are signed, and the sum wraps modulo 2^32.
- R5: With opcode 4, the result is the unsigned 64-bit product of word 0 of A and word 0 of B. Word 1 of both operands has no effect.
- R6: With opcode 5, each byte lane of the result is |A byte - B byte|, where both bytes are unsigned.
- R7: With opcode 6, bits [15:0] of the result are the unsigned sum of the eight bytes of A, and bits [63:16] are zero. Operand B has no effect.
- R8: With opcode 7, bits [15:0] of the result are the sum over all eight byte lanes of |A byte - B byte|, and bits [63:16] are zero.
- R9: The result depends only on the current inputs and holds no state between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select (encoding in R1 to R8) |
| src_a_i | input | 64 | Operand A |
| src_b_i | input | 64 | Operand B |
| res_o | output | 64 | Result |

## Verification
The embedded assertions are evaluated whenever the inputs change. They check a set of invariants: the low halves of the signed and unsigned halfword products agree, each byte difference is no larger than the larger of its two bytes, and both reductions leave bits [63:16] clear. They also check three degenerate cases: a zero B gives a zero multiply-add, equal operands give a zero SAD, and a B word of one makes the word multiply return word 0 of A. Exact lane values are shown only by the bench scenarios. These include the sign corners 0x8000*0x8000 and -1*-1, wraparound of the multiply-add, all-0xFF byte sums, and B having no effect on the byte sum.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [2:0] {
    OP_MUL_LO  = 3'd0,
    OP_MUL_HS  = 3'd1,
    OP_MUL_HU  = 3'd2,
    OP_MADD    = 3'd3,
    OP_MUL_W   = 3'd4,
    OP_ABSD    = 3'd5,
    OP_BSUM    = 3'd6,
    OP_SAD     = 3'd7
  } pmul_op_e;
endpackage

// File: rtl/pmul_half_lanes.sv
module pmul_half_lanes #(
  parameter int DATA_W = 64,
  parameter int H_W    = 16,
  localparam int NUM_H = DATA_W / H_W,
  localparam int P_W   = 2 * H_W
) (
  input  logic [DATA_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          b_i,
  output logic [NUM_H-1:0][P_W-1:0]  prod_s_o,
  output logic [NUM_H-1:0][P_W-1:0]  prod_u_o
);
  for (genvar g = 0; g < NUM_H; g++) begin : g_lane
    logic [H_W-1:0] a_h, b_h;
    assign a_h = a_i[g*H_W +: H_W];
    assign b_h = b_i[g*H_W +: H_W];
    // sign-extended operands: low P_W bits of the product are the signed product
    assign prod_s_o[g] = {{H_W{a_h[H_W-1]}}, a_h} * {{H_W{b_h[H_W-1]}}, b_h};
    assign prod_u_o[g] = {{H_W{1'b0}}, a_h} * {{H_W{1'b0}}, b_h};

    always_comb begin
      // R1
      lo_match_chk: assert (prod_s_o[g][H_W-1:0] == prod_u_o[g][H_W-1:0])
        else $error("signed/unsigned low product mismatch lane %0d", g);
    end
  end
endmodule

// File: rtl/pmul_byte_absdiff.sv
module pmul_byte_absdiff #(
  parameter int DATA_W = 64,
  parameter int B_W    = 8,
  localparam int NUM_B = DATA_W / B_W
) (
  input  logic [DATA_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          b_i,
  output logic [NUM_B-1:0][B_W-1:0]  diff_o
);
  for (genvar g = 0; g < NUM_B; g++) begin : g_byte
    logic [B_W-1:0] a_b, b_b;
    assign a_b = a_i[g*B_W +: B_W];
    assign b_b = b_i[g*B_W +: B_W];
    assign diff_o[g] = (a_b >= b_b) ? (a_b - b_b) : (b_b - a_b);

    always_comb begin
      // R6
      absd_bound_chk: assert (diff_o[g] <= ((a_b > b_b) ? a_b : b_b))
        else $error("byte difference exceeds operand lane %0d", g);
    end
  end
endmodule

// File: rtl/pmul_byte_sum.sv
module pmul_byte_sum #(
  parameter int NUM_B = 8,
  parameter int B_W   = 8,
  parameter int SUM_W = 16
) (
  input  logic [NUM_B-1:0][B_W-1:0] bytes_i,
  output logic [SUM_W-1:0]          sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NUM_B; i++) sum_o = sum_o + SUM_W'(bytes_i[i]);
  end
endmodule

// File: rtl/pmul_sad_unit.sv
module pmul_sad_unit
  import pmul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int H_W    = 16,
  parameter int B_W    = 8,
  localparam int NUM_H = DATA_W / H_W,
  localparam int NUM_B = DATA_W / B_W,
  localparam int W_W   = 2 * H_W,
  localparam int NUM_W = DATA_W / W_W
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [NUM_H-1:0][W_W-1:0] prod_s, prod_u;
  logic [NUM_B-1:0][B_W-1:0] diff;
  logic [NUM_B-1:0][B_W-1:0] sum_src;
  logic [H_W-1:0]            byte_sum;
  logic [DATA_W-1:0]         lo_v, hs_v, hu_v, madd_v, mulw_v;
  pmul_op_e                  op;

  assign op = pmul_op_e'(op_i);

  pmul_half_lanes #(.DATA_W(DATA_W), .H_W(H_W)) i_half (
    .a_i(src_a_i), .b_i(src_b_i), .prod_s_o(prod_s), .prod_u_o(prod_u)
  );

  pmul_byte_absdiff #(.DATA_W(DATA_W), .B_W(B_W)) i_absd (
    .a_i(src_a_i), .b_i(src_b_i), .diff_o(diff)
  );

  // one summing tree shared by plain byte sum and SAD
  assign sum_src = (op == OP_SAD) ? diff : src_a_i;

  pmul_byte_sum #(.NUM_B(NUM_B), .B_W(B_W), .SUM_W(H_W)) i_sum (
    .bytes_i(sum_src), .sum_o(byte_sum)
  );

  for (genvar g = 0; g < NUM_H; g++) begin : g_hsel
    assign lo_v[g*H_W +: H_W] = prod_s[g][H_W-1:0];
    assign hs_v[g*H_W +: H_W] = prod_s[g][W_W-1:H_W];
    assign hu_v[g*H_W +: H_W] = prod_u[g][W_W-1:H_W];
  end

  for (genvar g = 0; g < NUM_W; g++) begin : g_madd
    assign madd_v[g*W_W +: W_W] = prod_s[2*g] + prod_s[2*g+1];
  end

  assign mulw_v = DATA_W'(src_a_i[W_W-1:0]) * DATA_W'(src_b_i[W_W-1:0]);

  always_comb begin
    unique case (op)
      OP_MUL_LO: res_o = lo_v;
      OP_MUL_HS: res_o = hs_v;
      OP_MUL_HU: res_o = hu_v;
      OP_MADD:   res_o = madd_v;
      OP_MUL_W:  res_o = mulw_v;
      OP_ABSD:   res_o = diff;
      OP_BSUM,
      OP_SAD:    res_o = DATA_W'(byte_sum);
      default:   res_o = '0;
    endcase
  end

  always_comb begin
    // R4
    madd_zero_chk: assert (!(op == OP_MADD && src_b_i == '0) || res_o == '0)
      else $error("multiply-add with zero operand not zero");
    // R8
    sad_self_chk: assert (!(op == OP_SAD && src_a_i == src_b_i) || res_o == '0)
      else $error("SAD of equal operands not zero");
    // R7
    sum_hi_zero_chk: assert (!(op == OP_BSUM || op == OP_SAD) || res_o[DATA_W-1:H_W] == '0)
      else $error("reduction upper bits not clear");
    // R5
    mulw_ident_chk: assert (!(op == OP_MUL_W && src_b_i[W_W-1:0] == W_W'(1))
                            || res_o == DATA_W'(src_a_i[W_W-1:0]))
      else $error("word multiply by one mismatch");
  end
endmodule

// File: tb/test_pmul_sad_unit.sv
`timescale 1ns/1ps
module test_pmul_sad_unit;
  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [63:0] a, b, res;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

  always #2.5 clk = ~clk;

  pmul_sad_unit i_pmul_sad_unit (.op_i(op), .src_a_i(a), .src_b_i(b), .res_o(res));

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3";
      3'd3: return "R4";  3'd4: return "R5";  3'd5: return "R6";
      3'd6: return "R7";  default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = '0;
    logic [31:0] p;
    int          sx, sy, acc;
    case (o)
      3'd0, 3'd1, 3'd2: for (int i = 0; i < 4; i++) begin
        if (o == 3'd2) p = {16'h0, x[16*i +: 16]} * {16'h0, y[16*i +: 16]};
        else begin
          sx = int'($signed(x[16*i +: 16]));
          sy = int'($signed(y[16*i +: 16]));
          p = sx * sy;
        end
        r[16*i +: 16] = (o == 3'd0) ? p[15:0] : p[31:16];
      end
      3'd3: for (int w = 0; w < 2; w++) begin
        acc = int'($signed(x[32*w +: 16])) * int'($signed(y[32*w +: 16]))
            + int'($signed(x[32*w+16 +: 16])) * int'($signed(y[32*w+16 +: 16]));
        r[32*w +: 32] = acc;
      end
      3'd4: r = {32'h0, x[31:0]} * {32'h0, y[31:0]};
      3'd5: for (int i = 0; i < 8; i++)
        r[8*i +: 8] = (x[8*i +: 8] > y[8*i +: 8]) ? x[8*i +: 8] - y[8*i +: 8] : y[8*i +: 8] - x[8*i +: 8];
      3'd6: begin
        acc = 0;
        for (int i = 0; i < 8; i++) acc += int'(x[8*i +: 8]);
        r = 64'(acc);
      end
      default: begin
        acc = 0;
        for (int i = 0; i < 8; i++) begin
          sx = int'(x[8*i +: 8]); sy = int'(y[8*i +: 8]);
          acc += (sx > sy) ? sx - sy : sy - sx;
        end
        r = 64'(acc);
      end
    endcase
    return r;
  endfunction

  task automatic run(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y, input string tag);
    logic [63:0] exp;
    @(posedge clk); #1;
    op = o; a = x; b = y;
    exp = model(o, x, y);
    @(negedge clk);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", req_of(o), tag, o, x, y, res, exp);
    end
  endtask

  task automatic check_val(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] step(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  initial begin
    #(5 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    op = 3'd0; a = '0; b = '0;
    // R9: zero operands give zero in every operation, no state kept
    for (int o = 0; o < 8; o++) run(3'(o), 64'h0, 64'h0, "zero R9");
    // R1 wrap of low product
    run(3'd0, 64'hffff_8000_1234_00ff, 64'hffff_8000_0010_0101, "lo R1");
    // R2 sign corners: 0x8000*0x8000 and -1*-1, -1*1
    run(3'd1, 64'h8000_ffff_ffff_7fff, 64'h8000_ffff_0001_7fff, "hs R2");
    check_val("R2 corner", res, 64'h4000_0000_ffff_3fff);
    // R3 unsigned high of max values
    run(3'd2, 64'hffff_8000_ffff_0100, 64'hffff_8000_0001_0100, "hu R3");
    check_val("R3 corner", res, 64'hfffe_4000_0000_0001);
    // R4 wraparound: 2*(0x8000*0x8000) = 2^31, fits; -1*-1 + 1*1 = 2
    run(3'd3, 64'h8000_8000_0001_ffff, 64'h8000_8000_0001_ffff, "madd R4");
    check_val("R4 corner", res, 64'h8000_0000_0000_0002);
    // R5 upper words ignored
    run(3'd4, 64'hdead_beef_ffff_ffff, 64'h1111_2222_ffff_ffff, "mulw R5");
    check_val("R5 upper ignored", res, 64'hffff_fffe_0000_0001);
    // R6 byte difference both directions
    run(3'd5, 64'h00ff_1080_0102_ff00, 64'hff00_8010_0201_00ff, "absd R6");
    // R7 all 0xff bytes, B varied must not matter
    run(3'd6, 64'hffff_ffff_ffff_ffff, 64'h0, "bsum R7");
    check_val("R7 max sum", res, 64'h0000_0000_0000_07f8);
    run(3'd6, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0, "bsum B ignored R7");
    check_val("R7 B ignored", res, 64'h0000_0000_0000_07f8);
    // R8 maximal SAD
    run(3'd7, 64'hff00_ff00_ff00_ff00, 64'h00ff_00ff_00ff_00ff, "sad R8");
    check_val("R8 max", res, 64'h0000_0000_0000_07f8);
    // random patterns for every opcode
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 150; k++) begin
        logic [63:0] x, y;
        lfsr = step(lfsr); x = lfsr;
        lfsr = step(lfsr); y = lfsr;
        run(3'(o), x, y, "random");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule